// File: doc/BRIEF.md
# Programmable GPIO Input Debouncer

This block cleans up one asynchronous GPIO input before the rest of the chip uses it. The raw pin is first brought into the system clock domain. A filter then decides when the level seen inside the chip may change. Its timing comes from a slow reference clock. That clock reaches the block as a one-cycle tick pulse in the system clock domain.

Three configuration inputs set the filter. A two-bit mode picks the behaviour. Two unit bits pick how many reference ticks make one timing step. A four-bit count sets how many steps a new level must hold. The block has four modes:

- a bypass mode;
- a symmetric mode that removes every glitch;
- a mode that keeps low-going glitches, for pins that raise an active-high level interrupt;
- a mode that keeps high-going glitches, for active-low level pins.

Edge-triggered pins use the symmetric mode.

Top module: `gpio_debounce`

## Requirements
- R1: `pinSync` equals the value `pinRaw` had two rising clock edges earlier; it passes through a two-stage synchronizer.
- R2: With `cfgMode` = 0 (bypass), `pinFiltered` equals `pinSync` in the same cycle, whatever the unit and count inputs hold.
- R3: The unit bits `{cfgLarge,cfgUnit}` select one timing step of 2 (00), 8 (01), 512 (10) or 2048 (11) reference ticks.
- R4: A delayed transition reaches `pinFiltered` after the synchronized level has held for `cfgCount` steps (`cfgCount` from 1 to 15).
- R5: `cfgCount` = 0 behaves like a count of 1.
- R6: With `cfgMode` = 3 (full filter), rises and falls are both delayed as in R4. Any return of `pinSync` to the current filtered level restarts the timing from zero.
- R7: With `cfgMode` = 1 (keep low glitches), `pinFiltered` falls in the same cycle as `pinSync` falls, and a rise is delayed as in R4.
- R8: With `cfgMode` = 2 (keep high glitches), `pinFiltered` rises in the same cycle as `pinSync` rises, and a fall is delayed as in R4.
- R9: Any change of `cfgMode`, `cfgLarge`, `cfgUnit` or `cfgCount` clears the partial step and step count, so timing restarts from the change.
- R10: Only cycles with `rtcTick` high advance the timing; with `rtcTick` low, a pending transition never completes.
- R11: While `rstN` is low, `pinSync` and `pinFiltered` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rtcTick | input | 1 | One-cycle pulse per reference clock period |
| pinRaw | input | 1 | Asynchronous raw pin level |
| cfgMode | input | 2 | 0 bypass, 1 keep low glitches, 2 keep high glitches, 3 full filter |
| cfgLarge | input | 1 | Upper unit select bit |
| cfgUnit | input | 1 | Lower unit select bit |
| cfgCount | input | 4 | Number of steps a new level must hold |
| pinSync | output | 1 | Synchronized raw level |
| pinFiltered | output | 1 | Debounced level |

## Verification
Each check is tied to the rising clock edge on which its result is due. The bench always changes `pinRaw` just after a falling edge.

| Result | Due edge after the `pinRaw` change |
|---|---|
| `pinSync` | 2nd rising edge |
| Bypass and immediate (non-delayed) transitions | 2nd rising edge |
| Delayed transitions, `rtcTick` held high | edge 2 + U·max(N,1), where U is the step length and N the count |

For every transition, the bench samples at the falling edge after the edge just before the due one and expects the old level. It then samples after the due edge and expects the new level. A transition that is one edge early or one edge late therefore fails.

Restarts are checked the same way. For a bounce or a configuration change, the due edge is counted from the edge that cleared the timing. The bench also checks the old level at the edge where an unrestarted count would have finished.

// File: rtl/dbnc_pkg.sv
`timescale 1ns/1ps
package dbnc_pkg;

  typedef enum logic [1:0] {
    DB_BYPASS    = 2'd0,
    DB_KEEP_LOW  = 2'd1,
    DB_KEEP_HIGH = 2'd2,
    DB_FULL      = 2'd3
  } dbMode_e;

  // Strobes from the timing control to the filter datapath
  typedef struct packed {
    logic clear;     // timing cleared this cycle
    logic unitTick;  // one timing step completed
    logic commit;    // programmed hold time reached
  } dbStrobe_t;

endpackage

// File: rtl/dbnc_sync.sv
`timescale 1ns/1ps
module dbnc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= dIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/dbnc_ctrl.sv
`timescale 1ns/1ps
module dbnc_ctrl
  import dbnc_pkg::*;
#(
  parameter int UNIT_A = 2,
  parameter int UNIT_B = 8,
  parameter int UNIT_C = 512,
  parameter int UNIT_D = 2048,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rtcTick,
  input  logic [1:0]       cfgMode,
  input  logic             cfgLarge,
  input  logic             cfgUnit,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             pending,
  output dbStrobe_t        strobe
);
  localparam int PRE_W = $clog2(UNIT_D);
  localparam int CFG_W = 2 + 2 + CNT_W;

  logic [CFG_W-1:0] cfgWord, cfgQ;
  logic [PRE_W-1:0] preCnt, unitLast;
  logic [CNT_W-1:0] stepCnt, stepLast;
  logic             cfgChanged, preWrap;

  assign cfgWord    = {cfgMode, cfgLarge, cfgUnit, cfgCount};
  assign cfgChanged = (cfgWord != cfgQ);

  always_comb begin
    unique case ({cfgLarge, cfgUnit})
      2'b00:   unitLast = PRE_W'(UNIT_A - 1);
      2'b01:   unitLast = PRE_W'(UNIT_B - 1);
      2'b10:   unitLast = PRE_W'(UNIT_C - 1);
      default: unitLast = PRE_W'(UNIT_D - 1);
    endcase
  end

  // A zero count is treated as one step
  assign stepLast = (cfgCount == '0) ? '0 : cfgCount - 1'b1;
  assign preWrap  = rtcTick && (preCnt == unitLast);

  always_comb begin
    strobe.clear    = cfgChanged || !pending;
    strobe.unitTick = !strobe.clear && preWrap;
    strobe.commit   = strobe.unitTick && (stepCnt == stepLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      preCnt  <= '0;
      stepCnt <= '0;
    end else begin
      cfgQ <= cfgWord;
      if (strobe.clear) begin
        preCnt  <= '0;
        stepCnt <= '0;
      end else begin
        if (rtcTick) preCnt <= preWrap ? '0 : preCnt + 1'b1;
        if (strobe.unitTick) stepCnt <= strobe.commit ? '0 : stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbnc_datapath.sv
`timescale 1ns/1ps
module dbnc_datapath
  import dbnc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinSync,
  input  logic [1:0] cfgMode,
  input  dbStrobe_t strobe,
  output logic      pending,
  output logic      pinFiltered
);
  dbMode_e mode;
  logic    level;

  assign mode = dbMode_e'(cfgMode);

  always_comb begin
    unique case (mode)
      DB_BYPASS: begin
        pending     = 1'b0;
        pinFiltered = pinSync;
      end
      DB_KEEP_LOW: begin
        pending     = pinSync & ~level;
        pinFiltered = pinSync & level;
      end
      DB_KEEP_HIGH: begin
        pending     = ~pinSync & level;
        pinFiltered = pinSync | level;
      end
      default: begin
        pending     = pinSync ^ level;
        pinFiltered = level;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= 1'b0;
    end else begin
      unique case (mode)
        DB_BYPASS: level <= pinSync;
        DB_KEEP_LOW: begin
          if (!pinSync)           level <= 1'b0;
          else if (strobe.commit) level <= 1'b1;
        end
        DB_KEEP_HIGH: begin
          if (pinSync)            level <= 1'b1;
          else if (strobe.commit) level <= 1'b0;
        end
        default: if (strobe.commit) level <= pinSync;
      endcase
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
`timescale 1ns/1ps
module gpio_debounce
  import dbnc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int UNIT_A      = 2,
  parameter int UNIT_B      = 8,
  parameter int UNIT_C      = 512,
  parameter int UNIT_D      = 2048,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rtcTick,
  input  logic             pinRaw,
  input  logic [1:0]       cfgMode,
  input  logic             cfgLarge,
  input  logic             cfgUnit,
  input  logic [CNT_W-1:0] cfgCount,
  output logic             pinSync,
  output logic             pinFiltered
);
  dbStrobe_t strobe;
  logic      pending;

  dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .dIn(pinRaw), .dOut(pinSync)
  );

  dbnc_ctrl #(
    .UNIT_A(UNIT_A), .UNIT_B(UNIT_B), .UNIT_C(UNIT_C), .UNIT_D(UNIT_D),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick), .cfgMode(cfgMode),
    .cfgLarge(cfgLarge), .cfgUnit(cfgUnit), .cfgCount(cfgCount),
    .pending(pending), .strobe(strobe)
  );

  dbnc_datapath u_dp (
    .clk(clk), .rstN(rstN), .pinSync(pinSync), .cfgMode(cfgMode),
    .strobe(strobe), .pending(pending), .pinFiltered(pinFiltered)
  );
endmodule

// File: rtl/dbnc_checker.sv
`timescale 1ns/1ps
module dbnc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pinRaw,
  input logic       pinSync,
  input logic       pinFiltered,
  input logic [1:0] cfgMode
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;

  p_sync_delay_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (pinSync == $past(pinRaw, 2)));

  p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd0) |-> (pinFiltered == pinSync));

  p_full_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && cfgMode == 2'd3 && $past(cfgMode) == 2'd3 &&
     pinFiltered != $past(pinFiltered)) |-> (pinFiltered == $past(pinSync)));

  p_low_passes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd1 && !pinSync) |-> !pinFiltered);

  p_high_passes_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd2 && pinSync) |-> pinFiltered);
endmodule

bind gpio_debounce dbnc_checker u_chk (
  .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .pinSync(pinSync),
  .pinFiltered(pinFiltered), .cfgMode(cfgMode)
);

// File: tb/sim_gpio_debounce.sv
`timescale 1ns/1ps
module sim_gpio_debounce;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rtcTick = 1'b1;
  logic       pinRaw = 1'b1;
  logic [1:0] cfgMode = 2'd0;
  logic       cfgLarge = 1'b0;
  logic       cfgUnit = 1'b0;
  logic [3:0] cfgCount = 4'd0;
  logic       pinSync, pinFiltered;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  gpio_debounce u0 (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick), .pinRaw(pinRaw),
    .cfgMode(cfgMode), .cfgLarge(cfgLarge), .cfgUnit(cfgUnit),
    .cfgCount(cfgCount), .pinSync(pinSync), .pinFiltered(pinFiltered)
  );

  // {mode, large, unit, count, startPin, dueEdge}; rtcTick held high,
  // dueEdge = 2 for bypass and immediate passes, else 2 + U*max(N,1)
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 4'd3,  1'b0, 16'd8},    // R6 R4 rise
    {2'd3, 1'b0, 1'b0, 4'd3,  1'b1, 16'd8},    // R6 fall
    {2'd3, 1'b0, 1'b1, 4'd2,  1'b0, 16'd18},   // R3 unit 8
    {2'd3, 1'b1, 1'b0, 4'd1,  1'b0, 16'd514},  // R3 unit 512
    {2'd3, 1'b1, 1'b1, 4'd2,  1'b1, 16'd4098}, // R3 unit 2048
    {2'd3, 1'b0, 1'b0, 4'd0,  1'b0, 16'd4},    // R5 zero count
    {2'd1, 1'b0, 1'b0, 4'd2,  1'b0, 16'd6},    // R7 delayed rise
    {2'd1, 1'b0, 1'b0, 4'd2,  1'b1, 16'd2},    // R7 immediate fall
    {2'd2, 1'b0, 1'b1, 4'd1,  1'b1, 16'd10},   // R8 delayed fall
    {2'd2, 1'b0, 1'b1, 4'd1,  1'b0, 16'd2},    // R8 immediate rise
    {2'd0, 1'b1, 1'b1, 4'd15, 1'b0, 16'd2},    // R2 bypass
    {2'd3, 1'b0, 1'b0, 4'd15, 1'b1, 16'd32}    // R4 max count
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Park the filter at a known level through bypass, then apply a config
  task automatic settle(input logic lvl, input logic [1:0] m, input logic lg,
                        input logic un, input logic [3:0] n);
    cfgMode = 2'd0;
    pinRaw  = lvl;
    repeat (4) @(negedge clk);
    cfgMode = m; cfgLarge = lg; cfgUnit = un; cfgCount = n;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: reset holds both outputs low even with the pin high
    repeat (3) @(negedge clk);
    check("R11 pinSync in reset", pinSync, 1'b0);
    check("R11 pinFiltered in reset", pinFiltered, 1'b0);
    rstN = 1'b1;

    // R1: two-edge synchronizer
    settle(1'b0, 2'd0, 1'b0, 1'b0, 4'd0);
    pinRaw = 1'b1;
    @(negedge clk);
    check("R1 pinSync after 1 edge", pinSync, 1'b0);
    @(negedge clk);
    check("R1 pinSync after 2 edges", pinSync, 1'b1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [15:0] due;
      logic        st;
      due = VEC[v][15:0];
      st  = VEC[v][16];
      settle(st, VEC[v][24:23], VEC[v][22], VEC[v][21], VEC[v][20:17]);
      check($sformatf("R2-set vec%0d start", v), pinFiltered, st);
      pinRaw = ~st;
      repeat (int'(due) - 1) @(negedge clk);
      check($sformatf("vec%0d (R3 R4 R5 R6 R7 R8) before due", v), pinFiltered, st);
      @(negedge clk);
      check($sformatf("vec%0d (R3 R4 R5 R6 R7 R8) at due", v), pinFiltered, ~st);
    end

    // R6: short pulse is removed entirely
    settle(1'b0, 2'd3, 1'b0, 1'b0, 4'd3);
    pinRaw = 1'b1;
    repeat (4) @(negedge clk);
    pinRaw = 1'b0;
    repeat (20) @(negedge clk);
    check("R6 short pulse removed", pinFiltered, 1'b0);

    // R6: bounce restarts timing (clear at edge 8, commit at edge 14)
    pinRaw = 1'b1;
    repeat (5) @(negedge clk);
    pinRaw = 1'b0;
    @(negedge clk);
    pinRaw = 1'b1;
    repeat (7) @(negedge clk);
    check("R6 bounce restart before due", pinFiltered, 1'b0);
    @(negedge clk);
    check("R6 bounce restart at due", pinFiltered, 1'b1);

    // R7: single-cycle low glitch passes
    settle(1'b1, 2'd1, 1'b0, 1'b0, 4'd3);
    pinRaw = 1'b0;
    @(negedge clk);
    pinRaw = 1'b1;
    @(negedge clk);
    check("R7 low glitch passes", pinFiltered, 1'b0);

    // R8: single-cycle high glitch passes
    settle(1'b0, 2'd2, 1'b0, 1'b0, 4'd3);
    pinRaw = 1'b1;
    @(negedge clk);
    pinRaw = 1'b0;
    @(negedge clk);
    check("R8 high glitch passes", pinFiltered, 1'b1);

    // R9: config change mid count (clear at edge 6, commit at edge 16)
    settle(1'b0, 2'd3, 1'b0, 1'b0, 4'd4);
    pinRaw = 1'b1;
    repeat (5) @(negedge clk);
    cfgCount = 4'd5;
    repeat (5) @(negedge clk);
    check("R9 no commit at old due", pinFiltered, 1'b0);
    repeat (5) @(negedge clk);
    check("R9 before restarted due", pinFiltered, 1'b0);
    @(negedge clk);
    check("R9 at restarted due", pinFiltered, 1'b1);

    // R10: no reference ticks, no progress
    settle(1'b0, 2'd3, 1'b0, 1'b0, 4'd1);
    rtcTick = 1'b0;
    pinRaw  = 1'b1;
    repeat (40) @(negedge clk);
    check("R10 stalled without ticks", pinFiltered, 1'b0);
    rtcTick = 1'b1;
    @(negedge clk);
    check("R10 one tick not enough", pinFiltered, 1'b0);
    @(negedge clk);
    check("R10 completes after two ticks", pinFiltered, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule